// File: doc/BRIEF.md
# I2C Register-Access Target

This block is an I2C target that gives a bus master byte-wide access to a register space held elsewhere in the chip. The register space is reached through an 8-bit word pointer. After its own 7-bit address with the write direction, the master sends one byte that loads the pointer. Any further bytes in that write are stored at the pointer, and the pointer steps forward once for each byte.

A read starts at the pointer and returns registers in order for as long as the master acknowledges each byte. To read from a chosen location, the master sends a write that carries only the word address. It then issues a repeated START and the address with the read direction. A read that has no word-address phase continues from wherever the last access left the pointer.

The SDA and SCL pads are open-drain. The block samples both lines through synchronizer flops and only ever pulls SDA low through an output enable. On the register side it presents the pointer as an address, a one-cycle write strobe with data, and a read-data input. That input must follow the address within one clock.

Top module: `i2c_reg_target`

## Requirements
- R1: After synchronous reset, sda_oe and reg_we are low and the pointer (seen on reg_addr) is 00h.
- R2: The block pulls SDA low in the acknowledge slot only for its configured 7-bit address DEV_ADDR (address in bits 7..1, R/W in bit 0, 1 = read). On a mismatch it never pulls SDA and performs no register write until the next START.
- R3: In a write (R/W = 0), the first byte after the address loads the pointer. Every later byte is written to the pointer location with a single reg_we pulse. Each byte is acknowledged, and the pointer then increments.
- R4: A write of only the word address, followed by a repeated START and a read address, returns the register at that word address as the first byte.
- R5: While the master ACKs read bytes, the block sends the following registers in order. The pointer advances by one per byte delivered.
- R6: A read with no word-address phase starts at the pointer left by the previous access, including 00h straight after reset.
- R7: The pointer wraps from FFh to 00h, both in writes and in reads.
- R8: Read data is sent MSB first. After the master NACKs a byte, SDA is released.
- R9: sda_oe changes only while SCL is low.
- R10: reg_we is a single-cycle pulse, and reg_addr stays stable in the cycle that follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | Pull SDA low when 1 |
| reg_addr | output | 8 | Register address (current pointer) |
| reg_we | output | 1 | Register write strobe |
| reg_wdata | output | 8 | Register write data |
| reg_rdata | input | 8 | Register read data for reg_addr |

## Verification
The bench drives bit-level bus transactions and keeps its own copy of the register space and pointer. Each transaction is tried in several shapes:
- a current-address read straight after reset, which catches a pointer that does not reset to zero;
- a multi-byte write, followed by a random read through a repeated START, which separates pointer loading from data storage;
- a sequential read that continues from the previous pointer, which exposes missing or doubled increments;
- a transfer to a foreign address, which must leave the memory and the write-strobe count unchanged;
- a write and read across FFh, which checks the wrap.

The register contents are asymmetric, so the returned bytes also show any bit-order error.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DEVADR,
    ST_DEVACK,
    ST_PTR,
    ST_PTRACK,
    ST_WR,
    ST_WRACK,
    ST_RD,
    ST_RDACK
  } tgt_state_e;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic bus_start,
  output logic bus_stop
);
  logic [STAGES-1:0] scl_sh, sda_sh;
  logic scl_d, sda_d, scl_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[STAGES-2:0], scl_i};
      sda_sh <= {sda_sh[STAGES-2:0], sda_i};
      scl_d  <= scl_sh[STAGES-1];
      sda_d  <= sda_sh[STAGES-1];
    end
  end

  assign scl_s     = scl_sh[STAGES-1];
  assign sda_s     = sda_sh[STAGES-1];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign bus_start = scl_s & scl_d & sda_d & ~sda_s;
  assign bus_stop  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/i2c_ptr.sv
module i2c_ptr #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  input  logic          inc,
  output logic [AW-1:0] ptr
);
  always_ff @(posedge clk) begin
    if (rst)       ptr <= '0;
    else if (load) ptr <= load_val;
    else if (inc)  ptr <= ptr + 1'b1;   // natural wrap at the top
  end
endmodule

// File: rtl/i2c_reg_target.sv
module i2c_reg_target
  import i2c_tgt_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h50,
  parameter int         SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  output logic [7:0] reg_addr,
  output logic       reg_we,
  output logic [7:0] reg_wdata,
  input  logic [7:0] reg_rdata
);
  localparam int BYTE_W = 8;
  localparam int CNT_W  = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);

  logic sda_s, scl_rise, scl_fall, bus_start, bus_stop;
  tgt_state_e st;
  logic [BYTE_W-1:0] sh, wd_q, ptr;
  logic [CNT_W-1:0]  cnt;
  logic rw, mack, oe_q, we_q, ptr_load, ptr_inc, quiet;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .bus_start(bus_start), .bus_stop(bus_stop)
  );

  assign quiet    = ~bus_start & ~bus_stop;
  assign ptr_load = quiet & scl_fall & (st == ST_PTR) & (cnt == CNT_FULL);
  assign ptr_inc  = quiet & scl_fall &
                    ((st == ST_WRACK) | ((st == ST_RD) & (cnt == CNT_FULL)));

  i2c_ptr #(.AW(BYTE_W)) u_ptr (
    .clk(clk), .rst(rst), .load(ptr_load), .load_val(sh),
    .inc(ptr_inc), .ptr(ptr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= ST_IDLE;
      sh   <= '0;
      cnt  <= '0;
      rw   <= 1'b0;
      mack <= 1'b0;
      oe_q <= 1'b0;
      we_q <= 1'b0;
      wd_q <= '0;
    end else begin
      we_q <= 1'b0;
      if (bus_start) begin
        st   <= ST_DEVADR;
        cnt  <= '0;
        oe_q <= 1'b0;
      end else if (bus_stop) begin
        st   <= ST_IDLE;
        oe_q <= 1'b0;
      end else begin
        case (st)
          ST_DEVADR, ST_PTR, ST_WR: begin
            if (scl_rise && cnt != CNT_FULL) begin
              sh  <= {sh[BYTE_W-2:0], sda_s};
              cnt <= cnt + 1'b1;
            end else if (scl_fall && cnt == CNT_FULL) begin
              cnt <= '0;
              if (st == ST_DEVADR) begin
                if (sh[7:1] == DEV_ADDR) begin
                  rw   <= sh[0];
                  oe_q <= 1'b1;
                  st   <= ST_DEVACK;
                end else begin
                  st <= ST_IDLE;
                end
              end else if (st == ST_PTR) begin
                oe_q <= 1'b1;
                st   <= ST_PTRACK;
              end else begin
                oe_q <= 1'b1;
                we_q <= 1'b1;
                wd_q <= sh;
                st   <= ST_WRACK;
              end
            end
          end
          ST_DEVACK: begin
            if (scl_fall) begin
              if (rw) begin
                sh   <= reg_rdata;
                oe_q <= ~reg_rdata[BYTE_W-1];
                st   <= ST_RD;
              end else begin
                oe_q <= 1'b0;
                st   <= ST_PTR;
              end
            end
          end
          ST_PTRACK, ST_WRACK: begin
            if (scl_fall) begin
              oe_q <= 1'b0;
              st   <= ST_WR;
            end
          end
          ST_RD: begin
            if (scl_rise) begin
              cnt <= cnt + 1'b1;
            end else if (scl_fall) begin
              if (cnt == CNT_FULL) begin
                oe_q <= 1'b0;
                cnt  <= '0;
                st   <= ST_RDACK;
              end else begin
                oe_q <= ~sh[BYTE_W-2];
                sh   <= {sh[BYTE_W-2:0], 1'b0};
              end
            end
          end
          ST_RDACK: begin
            if (scl_rise) begin
              mack <= ~sda_s;
            end else if (scl_fall) begin
              if (mack) begin
                sh   <= reg_rdata;
                oe_q <= ~reg_rdata[BYTE_W-1];
                st   <= ST_RD;
              end else begin
                st <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_oe    = oe_q;
  assign reg_we    = we_q;
  assign reg_wdata = wd_q;
  assign reg_addr  = ptr;
endmodule

// File: rtl/i2c_reg_target_chk.sv
module i2c_reg_target_chk (
  input logic       clk,
  input logic       rst,
  input logic       scl_i,
  input logic       sda_oe,
  input logic       reg_we,
  input logic [7:0] reg_addr
);
  a_r1_reset_quiet: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!sda_oe && !reg_we && reg_addr == 8'h00));

  a_r9_sda_scl_low: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_oe) |-> !scl_i);

  a_r10_we_pulse: assert property (@(posedge clk) disable iff (rst)
    reg_we |=> !reg_we);

  a_r10_addr_hold: assert property (@(posedge clk) disable iff (rst)
    reg_we |=> $stable(reg_addr));
endmodule

bind i2c_reg_target i2c_reg_target_chk u_chk (
  .clk(clk), .rst(rst), .scl_i(scl_i), .sda_oe(sda_oe),
  .reg_we(reg_we), .reg_addr(reg_addr)
);

// File: tb/i2c_reg_target_bench.sv
module i2c_reg_target_bench;
  localparam int Q = 8;
  localparam logic [6:0] DEV = 7'h50;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic m_scl_low = 1'b0, m_sda_low = 1'b0;
  logic sda_oe, reg_we;
  logic [7:0] reg_addr, reg_wdata, reg_rdata;
  wire scl_i = ~m_scl_low;
  wire sda_i = ~(m_sda_low | sda_oe);

  logic [7:0] mem [256];
  logic [7:0] exp_mem [256];
  int exp_ptr = 0;
  int tests = 0, fails = 0, we_cnt = 0;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 256; i++) mem[i] <= 8'(i) ^ 8'h5A;
    end else if (reg_we) begin
      mem[reg_addr] <= reg_wdata;
    end
  end
  assign reg_rdata = mem[reg_addr];

  always @(posedge clk) if (!rst && reg_we) we_cnt++;

  i2c_reg_target #(.DEV_ADDR(DEV)) u_i2c_reg_target (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i), .sda_oe(sda_oe),
    .reg_addr(reg_addr), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata)
  );

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic q();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bstart();
    m_sda_low = 1'b0; q();
    m_scl_low = 1'b0; q();
    m_sda_low = 1'b1; q();
    m_scl_low = 1'b1; q();
  endtask

  task automatic bstop();
    m_sda_low = 1'b1; q();
    m_scl_low = 1'b0; q();
    m_sda_low = 1'b0; q();
  endtask

  task automatic bit_io(input logic b, output logic s);
    m_sda_low = ~b; q();
    m_scl_low = 1'b0; q();
    s = sda_i; q();
    m_scl_low = 1'b1; q();
  endtask

  task automatic wbyte(input logic [7:0] b, output logic ack);
    logic d;
    for (int i = 7; i >= 0; i--) bit_io(b[i], d);
    bit_io(1'b1, d);
    ack = ~d;
  endtask

  task automatic rbyte(input logic give_ack, output logic [7:0] v);
    logic d;
    v = '0;
    for (int i = 0; i < 8; i++) begin
      bit_io(1'b1, d);
      v = {v[6:0], d};
    end
    bit_io(~give_ack, d);
  endtask

  initial begin
    logic a;
    logic [7:0] v;
    int we_before;
    for (int i = 0; i < 256; i++) exp_mem[i] = 8'(i) ^ 8'h5A;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 sda_oe", sda_oe, 0);
    chk("R1 reg_we", reg_we, 0);
    chk("R1 pointer", reg_addr, 0);

    // R6: current-address read straight after reset
    bstart(); wbyte({DEV, 1'b1}, a); chk("R2 ack own read", a, 1);
    rbyte(1'b0, v); chk("R6 byte at reset pointer", v, exp_mem[exp_ptr]);
    exp_ptr = (exp_ptr + 1) % 256;
    chk("R8 released after nack", sda_oe, 0);
    bstop();

    // R3: multi-byte write
    bstart(); wbyte({DEV, 1'b0}, a); chk("R2 ack own write", a, 1);
    wbyte(8'h10, a); chk("R3 word address ack", a, 1);
    wbyte(8'hA1, a); chk("R3 data ack 1", a, 1);
    wbyte(8'hB2, a); chk("R3 data ack 2", a, 1);
    bstop();
    exp_mem[8'h10] = 8'hA1; exp_mem[8'h11] = 8'hB2; exp_ptr = 8'h12;
    chk("R3 pointer after write", reg_addr, exp_ptr);

    // R2: foreign address must be ignored
    we_before = we_cnt;
    bstart(); wbyte({7'h23, 1'b0}, a); chk("R2 nack foreign", a, 0);
    wbyte(8'h10, a); chk("R2 no ack later", a, 0);
    wbyte(8'hEE, a);
    bstop();
    chk("R2 no write", we_cnt, we_before);
    chk("R2 pointer untouched", reg_addr, exp_ptr);

    // R4 / R5: random read through a repeated START, then a sequential run
    bstart(); wbyte({DEV, 1'b0}, a); wbyte(8'h10, a);
    bstart(); wbyte({DEV, 1'b1}, a); chk("R4 ack read after rstart", a, 1);
    rbyte(1'b1, v); chk("R4 first byte", v, exp_mem[8'h10]);
    rbyte(1'b1, v); chk("R5 second byte", v, exp_mem[8'h11]);
    rbyte(1'b0, v); chk("R5 third byte", v, exp_mem[8'h12]);
    chk("R8 released after nack", sda_oe, 0);
    bstop();
    exp_ptr = 8'h13;
    chk("R5 pointer after run", reg_addr, exp_ptr);

    // R6: current-address read continues
    bstart(); wbyte({DEV, 1'b1}, a);
    rbyte(1'b1, v); chk("R6 continue", v, exp_mem[8'h13]);
    rbyte(1'b0, v); chk("R5 continue next", v, exp_mem[8'h14]);
    bstop();

    // R7: wrap at the top of the space
    bstart(); wbyte({DEV, 1'b0}, a); wbyte(8'hFF, a);
    wbyte(8'h3C, a); wbyte(8'hC3, a);
    bstop();
    exp_mem[8'hFF] = 8'h3C; exp_mem[8'h00] = 8'hC3;
    chk("R7 pointer wrap on write", reg_addr, 1);
    bstart(); wbyte({DEV, 1'b0}, a); wbyte(8'hFF, a);
    bstart(); wbyte({DEV, 1'b1}, a);
    rbyte(1'b1, v); chk("R7 read FF", v, exp_mem[8'hFF]);
    rbyte(1'b0, v); chk("R7 read 00 after wrap", v, exp_mem[8'h00]);
    bstop();
    chk("R7 pointer after wrapped read", reg_addr, 1);
    chk("R8 idle release", sda_oe, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule